// File: doc/BRIEF.md
# Power Partition Gate Controller

This block keeps the power and isolation-clamp state of up to 32 switchable power partitions behind a small register window. Software changes a partition's power by issuing a toggle command that carries a start flag and a partition index. The partition's power bit flips only after a fixed settle delay. While that delay runs, a busy flag is raised and the status bitmap still reports the old state.

Each partition has an isolation clamp. The clamp stays engaged while the partition is unpowered. Software releases clamps through a shared mask register. The mask bits for partitions 3 and 4 are cross-wired: mask bit 3 acts on partition 4, and mask bit 4 acts on partition 3. The graphics partition's clamp does not respond to the shared mask. It has its own register, and writing zero to that register releases the clamp.

The power switches themselves are modelled as internal state. The analog switching is not part of the block, and neither is the clock or reset sequencing of the partitions.

Top module: `pwr_part_ctrl`

## Requirements
- R1: After reset, every partition is unpowered, every clamp is engaged (clamp_o all ones), busy_o is 0, and the status register reads 0.
- R2: A write to offset 0x030 with bit 8 set flips the power of the partition whose index is in bits [4:0]. The change appears on power_o exactly SETTLE_CYC clock edges after the write edge.
- R3: From the write edge until the flip, busy_o is 1 and the status bitmap keeps its old value. busy_o returns to 0 on the same edge that the power bit changes.
- R4: A toggle write with bit 8 clear is ignored. A toggle write whose index is not below NUM_PART is also ignored, and it does not raise busy_o.
- R5: A toggle write that arrives while busy_o is 1 is ignored.
- R6: A read of offset 0x038 returns bit i set exactly when partition i is powered, with all bits from NUM_PART upward at zero. A read of any other offset returns 0, and a write to an unmapped offset has no effect.
- R7: A write to offset 0x034 releases, on its own edge, the clamp of each powered partition selected by a set mask bit. Mask bit 3 selects partition 4, mask bit 4 selects partition 3, and every other mask bit selects the partition with the same number.
- R8: The graphics partition (GFX_IDX, default 1) ignores the shared mask. Writing 0 to offset 0x2D4 releases its clamp when it is powered. A nonzero write to 0x2D4 has no effect.
- R9: A clamp release aimed at an unpowered partition has no effect. A partition's clamp is re-engaged on the same edge that its power turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 12 | Read byte offset |
| rd_data_o | output | 32 | Combinational read data |
| power_o | output | NUM_PART | Partition power state |
| clamp_o | output | NUM_PART | Partition clamp state, 1 = clamped |
| busy_o | output | 1 | Toggle settling in progress |

## Verification
The bench samples one cycle before the settle expires and again on the expiry cycle. A design that flips early, or that updates status before the switch settles, fails at one of those two samples. It releases clamps through mask bits 3 and 4 one at a time, so an implementation without the cross-wiring frees the wrong partition. It also sends the graphics partition's mask bit and a nonzero write to the dedicated register, to catch a clamp that either path wrongly frees. It issues toggles that lack the start flag, that carry an out-of-range index, or that arrive while busy, and powers off a released partition, to expose a design that acts on a rejected command or forgets to re-clamp.

// File: rtl/pwr_part_pkg.sv
package pwr_part_pkg;
  localparam logic [11:0] OFF_TOGGLE    = 12'h030;
  localparam logic [11:0] OFF_CLAMP_REL = 12'h034;
  localparam logic [11:0] OFF_STATUS    = 12'h038;
  localparam logic [11:0] OFF_GFX_CLAMP = 12'h2D4;
  localparam int START_BIT = 8;
  localparam int MAX_PART  = 32;
  localparam int IDX_W     = $clog2(MAX_PART);
endpackage

// File: rtl/pwr_toggle_seq.sv
module pwr_toggle_seq
  import pwr_part_pkg::*;
#(
  parameter int NUM_PART   = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                busy_o,
  output logic [NUM_PART-1:0] power_o,
  output logic [NUM_PART-1:0] power_nxt_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

  logic                busy_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic [NUM_PART-1:0] power_q;
  logic                accept, expire;

  assign accept = req_i && !busy_q && (32'(idx_i) < 32'(NUM_PART));
  assign expire = busy_q && (cnt_q == '0);

  always_comb begin
    power_nxt_o = power_q;
    for (int i = 0; i < NUM_PART; i++)
      if (expire && idx_q == IDX_W'(i)) power_nxt_o[i] = ~power_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      power_q <= '0;
    end else begin
      power_q <= power_nxt_o;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
        idx_q  <= idx_i;
      end else if (expire) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign power_o = power_q;

  AST_HOLD_WHILE_SETTLING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> $stable(power_q)); // R3
  AST_SINGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(power_q ^ $past(power_q)) <= 1); // R2
  AST_BUSY_END_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> power_q != $past(power_q)); // R2
  AST_STAY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q && $stable(idx_q)); // R5
endmodule

// File: rtl/pwr_clamp_bank.sv
module pwr_clamp_bank #(
  parameter int NUM_PART = 16,
  parameter int GFX_IDX  = 1,
  parameter int SWAP_A   = 3,
  parameter int SWAP_B   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mask_we_i,
  input  logic [NUM_PART-1:0] mask_i,
  input  logic                gfx_rel_i,
  input  logic [NUM_PART-1:0] power_nxt_i,
  output logic [NUM_PART-1:0] clamp_o
);
  logic [NUM_PART-1:0] rel;
  logic [NUM_PART-1:0] clamp_q;

  for (genvar i = 0; i < NUM_PART; i++) begin : g_rel
    localparam int SRC = (i == SWAP_A) ? SWAP_B : (i == SWAP_B) ? SWAP_A : i;
    if (i == GFX_IDX) begin : g_gfx
      assign rel[i] = gfx_rel_i;
    end else begin : g_mask
      assign rel[i] = mask_we_i & mask_i[SRC];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clamp_q <= '1;
    else         clamp_q <= ~power_nxt_i | (clamp_q & ~rel);
  end

  assign clamp_o = clamp_q;

  AST_GFX_DEDICATED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gfx_rel_i && clamp_q[GFX_IDX] |=> clamp_q[GFX_IDX]); // R8
endmodule

// File: rtl/pwr_part_ctrl.sv
module pwr_part_ctrl
  import pwr_part_pkg::*;
#(
  parameter int NUM_PART   = 16,
  parameter int SETTLE_CYC = 8,
  parameter int GFX_IDX    = 1,
  parameter int SWAP_A     = 3,
  parameter int SWAP_B     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [11:0]         wr_addr_i,
  input  logic [31:0]         wr_data_i,
  input  logic [11:0]         rd_addr_i,
  output logic [31:0]         rd_data_o,
  output logic [NUM_PART-1:0] power_o,
  output logic [NUM_PART-1:0] clamp_o,
  output logic                busy_o
);
  logic                tog_req, mask_we, gfx_rel;
  logic [NUM_PART-1:0] power_nxt;

  assign tog_req = wr_en_i && wr_addr_i == OFF_TOGGLE && wr_data_i[START_BIT];
  assign mask_we = wr_en_i && wr_addr_i == OFF_CLAMP_REL;
  assign gfx_rel = wr_en_i && wr_addr_i == OFF_GFX_CLAMP && wr_data_i == '0;

  pwr_toggle_seq #(.NUM_PART(NUM_PART), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (tog_req),
    .idx_i       (wr_data_i[IDX_W-1:0]),
    .busy_o      (busy_o),
    .power_o     (power_o),
    .power_nxt_o (power_nxt)
  );

  pwr_clamp_bank #(.NUM_PART(NUM_PART), .GFX_IDX(GFX_IDX),
                   .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)) u_clamp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we),
    .mask_i      (wr_data_i[NUM_PART-1:0]),
    .gfx_rel_i   (gfx_rel),
    .power_nxt_i (power_nxt),
    .clamp_o     (clamp_o)
  );

  assign rd_data_o = (rd_addr_i == OFF_STATUS) ? 32'(power_o) : 32'd0;

  AST_CLAMP_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~power_o & ~clamp_o) == '0); // R9
endmodule

// File: tb/sim_pwr_part_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_part_ctrl;
  localparam int N = 16;
  localparam int S = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [11:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [11:0]  rd_addr = 12'h038;
  logic [31:0]  rd_data;
  logic [N-1:0] power, clamp;
  logic         busy;

  typedef struct {
    string       req;
    int          kind;   // 0 status read, 1 clamp, 2 busy, 3 power
    logic [31:0] exp;
  } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_part_ctrl #(.NUM_PART(N), .SETTLE_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .power_o(power), .clamp_o(clamp), .busy_o(busy));

  task automatic push(string req, int kind, logic [31:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    exp_q.push_back(it);
  endtask

  task automatic monitor();
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = rd_data;
        1: act = 32'(clamp);
        2: act = 32'(busy);
        default: act = 32'(power);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    push("R1", 0, 0); push("R1", 1, 32'hFFFF); push("R1", 2, 0); push("R1", 3, 0);
    monitor();

    // R2 R3 power on partition 3
    wr(12'h030, 32'h103);
    idle(S - 1);
    push("R3", 0, 0); push("R3", 2, 1); monitor();
    idle(1);
    push("R2", 0, 32'h8); push("R3", 2, 0); monitor();

    // R4 no start bit; index out of range
    wr(12'h030, 32'h005);
    push("R4", 2, 0); monitor();
    idle(S + 1);
    push("R4", 0, 32'h8); monitor();
    wr(12'h030, 32'h11F);
    push("R4", 2, 0); monitor();
    idle(S + 1);
    push("R4", 0, 32'h8); monitor();

    // R5 toggle while busy is dropped
    wr(12'h030, 32'h104);
    wr(12'h030, 32'h106);
    idle(S);
    push("R5", 0, 32'h18); monitor();
    idle(S + 2);
    push("R5", 0, 32'h18); push("R5", 2, 0); monitor();

    // R7 swapped mask bits
    wr(12'h034, 32'h8);
    push("R7", 1, 32'hFFEF); monitor();
    wr(12'h034, 32'h10);
    push("R7", 1, 32'hFFE7); monitor();

    // R9 release on unpowered partition
    wr(12'h034, 32'h1);
    push("R9", 1, 32'hFFE7); monitor();

    // R8 graphics clamp
    wr(12'h030, 32'h101);
    idle(S);
    push("R8", 0, 32'h1A); monitor();
    wr(12'h034, 32'h2);
    push("R8", 1, 32'hFFE7); monitor();
    wr(12'h2D4, 32'h5);
    push("R8", 1, 32'hFFE7); monitor();
    wr(12'h2D4, 32'h0);
    push("R8", 1, 32'hFFE5); monitor();

    // R9 re-clamp on power off of partition 3
    wr(12'h030, 32'h103);
    idle(S - 1);
    push("R9", 1, 32'hFFE5); push("R9", 0, 32'h1A); monitor();
    idle(1);
    push("R9", 0, 32'h12); push("R9", 1, 32'hFFED); monitor();

    // R6 unmapped read/write
    wr(12'h040, 32'h102);
    idle(S + 1);
    push("R6", 3, 32'h12); push("R6", 1, 32'hFFED); monitor();
    rd_addr = 12'h030;
    #1;
    push("R6", 0, 0); monitor();
    rd_addr = 12'h038;
    #1;
    push("R6", 0, 32'h12); monitor();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule